// File: doc/BRIEF.md
# Predicated Vector Fixed/Float Converter

This block converts every lane of a 128-bit vector in one direction between IEEE floating point and binary fixed point. The vector is split either into eight 16-bit lanes, where half-precision values pair with 16-bit integers, or into four 32-bit lanes, where single-precision values pair with 32-bit integers. Each operation chooses the direction, signed or unsigned integers, the lane size and a count of fraction bits. The fixed-point number is read as an integer scaled by two to the minus that count.

A 16-bit predicate holds one bit per byte of the vector. Result bytes are written only where their predicate bit is set, and all other bytes keep the old destination value. A lane reports exceptions only when the predicate bit of its lowest byte is set. A lane whose only set bits lie higher still has its enabled bytes written, but it raises no flag. Exception flags are sticky and are cleared only by reset. An operation enters on `valid_in` and its result leaves on `valid_out` two cycles later. A new operation may enter on every cycle.

Top module: `vfx_convert`

## Requirements
- R1: With `half_lanes`=1, lane i occupies bits [16i+15:16i], i from 0 to 7, and uses predicate bits 2i and 2i+1. With `half_lanes`=0, lane j occupies bits [32j+31:32j], j from 0 to 3, and uses predicate bits 4j to 4j+3.
- R2: With `to_fixed`=0, each lane integer (two's complement when `int_signed`=1, plain binary otherwise) is divided by 2^`frac_bits`. The quotient is rounded to the nearest representable value, with ties going to the even value. Integer zero gives +0, and any rounded result raises Inexact.
- R3: With `to_fixed`=1, each lane float is multiplied by 2^`frac_bits` and truncated toward zero. Inexact is raised when nonzero bits are discarded.
- R4: In float-to-fixed mode, a truncated value above the integer range gives the maximum integer, and one below the range gives the minimum (0 when unsigned). Infinities saturate the same way by sign. NaN gives 0. All of these raise Invalid and never Inexact.
- R5: A float input with zero exponent and nonzero fraction is treated as zero. It gives integer 0 and raises Input-Denormal.
- R6: In half-precision fixed-to-float mode, a nonzero value whose biased exponent before rounding is below 1 gives a zero of the same sign and raises Underflow. Inexact is not raised for it.
- R7: Byte b of `dst_new` takes the converted byte when `lane_pred[b]`=1 and keeps the matching `dst_old` byte otherwise.
- R8: A lane raises flags only when the predicate bit of its lowest byte is 1. A lane whose other predicate bits are set still writes those bytes.
- R9: `flags` bit 0 is Invalid, bit 1 is Underflow, bit 2 is Inexact and bit 3 is Input-Denormal. The flags accumulate by OR and are cleared only by reset.
- R10: `valid_out` is 1 exactly two cycles after `valid_in` was 1, back-to-back operations included. `dst_new` and `flags` change only in cycles where `valid_out` is 1.
- R11: `frac_bits` is legal from 1 to 16 for 16-bit lanes and from 1 to 32 for 32-bit lanes, and both end values convert correctly.
- R12: While reset is low, `valid_out`, `dst_new` and `flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | An operation is presented this cycle |
| to_fixed | input | 1 | 1: float to fixed, 0: fixed to float |
| int_signed | input | 1 | Integer side is two's complement |
| half_lanes | input | 1 | 1: eight 16-bit lanes, 0: four 32-bit lanes |
| frac_bits | input | 6 | Number of fraction bits of the fixed-point side |
| lane_pred | input | 16 | Per-byte predicate |
| src_vec | input | 128 | Source vector |
| dst_old | input | 128 | Previous destination contents |
| valid_out | output | 1 | Result present on `dst_new` |
| dst_new | output | 128 | Merged destination vector |
| flags | output | 4 | Sticky exception flags |

## Verification
The bench builds the block with its default parameters: a 128-bit vector and a 6-bit fraction field. These defaults bring both lane sizes and both ends of each fraction range within reach. They also cover the half-precision underflow corner at 16 fraction bits and the carry from mantissa rounding into the exponent. Saturation exactly at the signed minimum, single-precision denormal inputs, and predicate patterns that split a lane between written and kept bytes are exercised too. An independent model built on real arithmetic predicts each lane, and a scoreboard compares every result against it.

// File: rtl/vfx_pkg.sv
package vfx_pkg;
  localparam int VEC_W  = 128;
  localparam int BYTE_W = 8;
  localparam int NBYTE  = VEC_W / BYTE_W;
  localparam int HALF_W = 16;
  localparam int SGL_W  = 32;
  localparam int NHALF  = VEC_W / HALF_W;
  localparam int NSGL   = VEC_W / SGL_W;
  localparam int FB_W   = 6;
  localparam int FLAG_W = 4;

  typedef struct packed {
    logic in_denorm;
    logic inexact;
    logic underflow;
    logic invalid;
  } vfx_flags_t;

  typedef struct packed {
    logic            to_fix;
    logic            is_signed;
    logic            half;
    logic [FB_W-1:0] fbits;
  } vfx_ctl_t;

  typedef struct packed {
    logic [SGL_W-1:0] val;
    vfx_flags_t       fl;
  } vfx_res_t;

  function automatic logic [5:0] lead_one(input logic [31:0] v);
    logic [5:0] p;
    p = 6'd0;
    for (int i = 0; i < 32; i++) if (v[i]) p = 6'(i);
    return p;
  endfunction

  // integer scaled by 2^-fb to float, round to nearest even
  function automatic vfx_res_t int_to_flt(input logic [31:0] iv, input logic half,
                                          input logic sgn, input logic [FB_W-1:0] fb);
    vfx_res_t    r;
    logic [31:0] xv, mag, norm, fr, frac, pk;
    logic        neg, g, st, rnd;
    logic [5:0]  p;
    int          mw, bias, be;
    r    = '0;
    mw   = half ? 10 : 23;
    bias = half ? 15 : 127;
    if (half) xv = sgn ? {{16{iv[15]}}, iv[15:0]} : {16'd0, iv[15:0]};
    else      xv = iv;
    neg = sgn & xv[31];
    mag = neg ? (~xv + 32'd1) : xv;
    if (mag != 32'd0) begin
      p    = lead_one(mag);
      norm = mag << (6'd31 - p);
      fr   = norm << 1;
      frac = fr >> (32 - mw);
      g    = fr[31 - mw];
      st   = |(fr << (mw + 1));
      be   = int'(p) - int'(fb) + bias;
      if (be < 1) begin
        r.fl.underflow = 1'b1;
        pk = '0;
      end else begin
        rnd = g & (st | frac[0]);
        pk  = ((32'(be) << mw) | frac) + {31'd0, rnd};
        r.fl.inexact = g | st;
      end
      r.val = half ? {16'd0, neg, pk[14:0]} : {neg, pk[30:0]};
    end
    return r;
  endfunction

  // float times 2^fb to integer, truncate toward zero, saturate
  function automatic vfx_res_t flt_to_int(input logic [31:0] fv, input logic half,
                                          input logic sgn, input logic [FB_W-1:0] fb);
    vfx_res_t    r;
    logic        s, lost, big;
    int          e, mw, bias, emax, w, k;
    logic [22:0] f;
    logic [63:0] mant, mag, pos_lim, neg_lim;
    logic [31:0] smax, smin, umax;
    r    = '0;
    mw   = half ? 10 : 23;
    bias = half ? 15 : 127;
    emax = half ? 31 : 255;
    w    = half ? 16 : 32;
    s    = half ? fv[15] : fv[31];
    e    = half ? int'(fv[14:10]) : int'(fv[30:23]);
    f    = half ? {13'd0, fv[9:0]} : fv[22:0];
    umax = half ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    smax = half ? 32'h0000_7FFF : 32'h7FFF_FFFF;
    smin = half ? 32'h0000_8000 : 32'h8000_0000;
    lost = 1'b0;
    big  = 1'b0;
    mag  = '0;
    if (e == emax) begin
      r.fl.invalid = 1'b1;
      if (f == 23'd0) r.val = s ? (sgn ? smin : 32'd0) : (sgn ? smax : umax);
    end else if (e == 0) begin
      r.fl.in_denorm = (f != 23'd0);
    end else begin
      mant = (64'd1 << mw) | {41'd0, f};
      k    = e - bias + int'(fb) - mw;
      if (k >= 40)      big = 1'b1;
      else if (k >= 0)  mag = mant << k;
      else if (k <= -25) lost = 1'b1;
      else begin
        mag  = mant >> (-k);
        lost = |(mant & ((64'd1 << (-k)) - 64'd1));
      end
      pos_lim = sgn ? ((64'd1 << (w - 1)) - 64'd1) : ((64'd1 << w) - 64'd1);
      neg_lim = sgn ? (64'd1 << (w - 1)) : 64'd0;
      if (!s && (big || mag > pos_lim)) begin
        r.val = sgn ? smax : umax;
        r.fl.invalid = 1'b1;
      end else if (s && (big || mag > neg_lim)) begin
        r.val = sgn ? smin : 32'd0;
        r.fl.invalid = 1'b1;
      end else begin
        r.val = (s ? (~mag[31:0] + 32'd1) : mag[31:0]) & umax;
        r.fl.inexact = lost;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/vfx_lane.sv
module vfx_lane
  import vfx_pkg::*;
#(
  parameter int LW = HALF_W
) (
  input  vfx_ctl_t      ctl,
  input  logic [LW-1:0] din,
  output logic [LW-1:0] dout,
  output vfx_flags_t    fl
);
  localparam logic IS_HALF = (LW == HALF_W);

  vfx_res_t    res;
  logic [31:0] dw;
  logic        nan_in, denorm_in;

  assign dw = 32'(din);
  assign nan_in    = IS_HALF ? (dw[14:10] == 5'h1F && dw[9:0] != 10'd0)
                             : (dw[30:23] == 8'hFF && dw[22:0] != 23'd0);
  assign denorm_in = IS_HALF ? (dw[14:10] == 5'h00 && dw[9:0] != 10'd0)
                             : (dw[30:23] == 8'h00 && dw[22:0] != 23'd0);

  always_comb begin
    if (ctl.to_fix) res = flt_to_int(dw, IS_HALF, ctl.is_signed, ctl.fbits);
    else            res = int_to_flt(dw, IS_HALF, ctl.is_signed, ctl.fbits);
  end

  assign dout = res.val[LW-1:0];
  assign fl   = res.fl;

  always_comb begin
    if (ctl.to_fix && nan_in)
      assert_nan_zero_R4: assert (dout == '0 && fl.invalid);
    if (ctl.to_fix && denorm_in)
      assert_denorm_zero_R5: assert (dout == '0 && fl.in_denorm && !fl.invalid);
    assert_inv_excl_R4: assert (!(fl.invalid && fl.inexact));
  end
endmodule

// File: rtl/vfx_pred_merge.sv
module vfx_pred_merge
  import vfx_pkg::*;
#(
  parameter int NB = NBYTE
) (
  input  logic                     half,
  input  logic [NB-1:0]            pred,
  input  logic [NB*BYTE_W-1:0]     old_v,
  input  logic [NB*BYTE_W-1:0]     new_h,
  input  logic [NB*BYTE_W-1:0]     new_s,
  input  vfx_flags_t [NB/2-1:0]    fl_h,
  input  vfx_flags_t [NB/4-1:0]    fl_s,
  output logic [NB*BYTE_W-1:0]     merged,
  output vfx_flags_t               fl_any
);
  localparam int NH = NB / 2;
  localparam int NS = NB / 4;

  logic [NB*BYTE_W-1:0] pick;
  logic [NH-1:0]        h_raise;
  logic [NS-1:0]        s_raise;

  assign pick = half ? new_h : new_s;

  for (genvar i = 0; i < NH; i++) begin : g_hraise
    assign h_raise[i] = half & pred[2*i];
  end
  for (genvar j = 0; j < NS; j++) begin : g_sraise
    assign s_raise[j] = ~half & pred[4*j];
  end
  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign merged[b*BYTE_W +: BYTE_W] = pred[b] ? pick[b*BYTE_W +: BYTE_W]
                                                : old_v[b*BYTE_W +: BYTE_W];
  end

  always_comb begin
    fl_any = '0;
    for (int i = 0; i < NH; i++) if (h_raise[i]) fl_any = fl_any | fl_h[i];
    for (int j = 0; j < NS; j++) if (s_raise[j]) fl_any = fl_any | fl_s[j];
  end
endmodule

// File: rtl/vfx_convert.sv
module vfx_convert
  import vfx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic              to_fixed,
  input  logic              int_signed,
  input  logic              half_lanes,
  input  logic [FB_W-1:0]   frac_bits,
  input  logic [NBYTE-1:0]  lane_pred,
  input  logic [VEC_W-1:0]  src_vec,
  input  logic [VEC_W-1:0]  dst_old,
  output logic              valid_out,
  output logic [VEC_W-1:0]  dst_new,
  output logic [FLAG_W-1:0] flags
);
  logic             s1_v;
  vfx_ctl_t         s1_ctl;
  logic [VEC_W-1:0] s1_src, s1_old;
  logic [NBYTE-1:0] s1_pred;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_ctl  <= '0;
      s1_src  <= '0;
      s1_old  <= '0;
      s1_pred <= '0;
    end else begin
      s1_v <= valid_in;
      if (valid_in) begin
        s1_ctl  <= {to_fixed, int_signed, half_lanes, frac_bits};
        s1_src  <= src_vec;
        s1_old  <= dst_old;
        s1_pred <= lane_pred;
      end
    end
  end

  logic [VEC_W-1:0]       res_h, res_s, merged;
  vfx_flags_t [NHALF-1:0] fl_h;
  vfx_flags_t [NSGL-1:0]  fl_s;
  vfx_flags_t             fl_new;

  for (genvar gi = 0; gi < NHALF; gi++) begin : g_half
    vfx_lane #(.LW(HALF_W)) u_lane (
      .ctl (s1_ctl),
      .din (s1_src[gi*HALF_W +: HALF_W]),
      .dout(res_h[gi*HALF_W +: HALF_W]),
      .fl  (fl_h[gi])
    );
  end
  for (genvar gj = 0; gj < NSGL; gj++) begin : g_sgl
    vfx_lane #(.LW(SGL_W)) u_lane (
      .ctl (s1_ctl),
      .din (s1_src[gj*SGL_W +: SGL_W]),
      .dout(res_s[gj*SGL_W +: SGL_W]),
      .fl  (fl_s[gj])
    );
  end

  vfx_pred_merge #(.NB(NBYTE)) u_merge (
    .half  (s1_ctl.half),
    .pred  (s1_pred),
    .old_v (s1_old),
    .new_h (res_h),
    .new_s (res_s),
    .fl_h  (fl_h),
    .fl_s  (fl_s),
    .merged(merged),
    .fl_any(fl_new)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_out <= 1'b0;
      dst_new   <= '0;
      flags     <= '0;
    end else begin
      valid_out <= s1_v;
      if (s1_v) begin
        dst_new <= merged;
        flags   <= flags | fl_new;
      end
    end
  end

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> ##1 valid_out);
  assert_no_orphan_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> $past(valid_in, 2));
  assert_quiet_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_out |-> $stable(flags));
  assert_sticky_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(flags)) == $past(flags)));
  assert_fbits_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |-> (frac_bits != '0 && frac_bits <= (half_lanes ? FB_W'(HALF_W) : FB_W'(SGL_W))));
  for (genvar b = 0; b < NBYTE; b++) begin : g_keep
    assert_keep_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && !lane_pred[b]) |=> ##1
        (dst_new[b*BYTE_W +: BYTE_W] == $past(dst_old[b*BYTE_W +: BYTE_W], 2)));
  end
endmodule

// File: tb/vfx_convert_bench.sv
module vfx_convert_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_in = 1'b0, to_fixed = 1'b0, int_signed = 1'b0, half_lanes = 1'b0;
  logic [5:0]   frac_bits = 6'd1;
  logic [15:0]  lane_pred = '0;
  logic [127:0] src_vec = '0, dst_old = '0;
  logic         valid_out;
  logic [127:0] dst_new;
  logic [3:0]   flags;

  vfx_convert u_vfx_convert (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .to_fixed(to_fixed),
    .int_signed(int_signed), .half_lanes(half_lanes), .frac_bits(frac_bits),
    .lane_pred(lane_pred), .src_vec(src_vec), .dst_old(dst_old),
    .valid_out(valid_out), .dst_new(dst_new), .flags(flags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  logic [127:0] q_d[$];
  logic [3:0]   q_f[$];
  string        q_r[$];
  logic [3:0]   model_flags = '0;

  function automatic real p2(int n);
    real r = 1.0;
    if (n >= 0) repeat (n) r = r * 2.0;
    else repeat (-n) r = r / 2.0;
    return r;
  endfunction

  function automatic logic [35:0] ref_i2f(logic [31:0] iv, bit hf, bit sg, int fb);
    real x, a, sc, rem;
    int e, mw, bias, be;
    longint ip;
    logic [3:0] fl;
    logic [31:0] v;
    bit ng;
    fl = 0; v = 0;
    mw = hf ? 10 : 23; bias = hf ? 15 : 127;
    if (hf) x = sg ? real'($signed(iv[15:0])) : real'(longint'(iv[15:0]));
    else    x = sg ? real'($signed(iv)) : real'(longint'(iv));
    x = x / p2(fb);
    if (x != 0.0) begin
      ng = (x < 0.0); a = ng ? -x : x; e = 0;
      while (a >= 2.0) begin a = a / 2.0; e++; end
      while (a < 1.0) begin a = a * 2.0; e--; end
      be = e + bias;
      if (be < 1) fl[1] = 1'b1;
      else begin
        sc = a * p2(mw);
        ip = longint'($floor(sc));
        rem = sc - real'(ip);
        if (rem != 0.0) fl[2] = 1'b1;
        if (rem > 0.5 || (rem == 0.5 && ip[0])) ip++;
        if (ip == (longint'(1) << (mw + 1))) begin ip = ip / 2; be++; end
        v = 32'(longint'(be) * (longint'(1) << mw) + (ip - (longint'(1) << mw)));
      end
      if (ng) v = v | (hf ? 32'h0000_8000 : 32'h8000_0000);
    end
    return {fl, v};
  endfunction

  function automatic logic [35:0] ref_f2i(logic [31:0] fv, bit hf, bit sg, int fb);
    bit s, big;
    int ex, mw, bias, emax, w;
    longint fr, ip, hi, lo;
    real t;
    logic [3:0] fl;
    logic [31:0] v, mk;
    fl = 0; v = 0;
    mw = hf ? 10 : 23; bias = hf ? 15 : 127; emax = hf ? 31 : 255; w = hf ? 16 : 32;
    mk = hf ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    if (hf) begin s = fv[15]; ex = int'(fv[14:10]); fr = longint'(fv[9:0]); end
    else    begin s = fv[31]; ex = int'(fv[30:23]); fr = longint'(fv[22:0]); end
    hi = sg ? (longint'(1) << (w - 1)) - 1 : (longint'(1) << w) - 1;
    lo = sg ? (longint'(1) << (w - 1)) : 0;
    if (ex == emax) begin
      fl[0] = 1'b1;
      if (fr == 0) v = s ? (32'(-lo) & mk) : 32'(hi);
    end else if (ex == 0) begin
      if (fr != 0) fl[3] = 1'b1;
    end else begin
      t = (1.0 + real'(fr) / p2(mw)) * p2(ex - bias + fb);
      big = (t >= p2(40));
      ip = big ? 0 : longint'($floor(t));
      if (!s && (big || ip > hi)) begin v = 32'(hi); fl[0] = 1'b1; end
      else if (s && (big || ip > lo)) begin v = 32'(-lo) & mk; fl[0] = 1'b1; end
      else begin
        v = 32'(s ? -ip : ip) & mk;
        if (t != real'(ip)) fl[2] = 1'b1;
      end
    end
    return {fl, v};
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: computes the expected item and presents the operation
  task automatic issue(string req, bit tf, bit sg, bit hf, int fb, logic [15:0] pr,
                       logic [127:0] s, logic [127:0] o);
    logic [127:0] nv, ev;
    logic [3:0] acc;
    logic [35:0] rr;
    logic [31:0] li;
    nv = '0; acc = '0;
    for (int l = 0; l < (hf ? 8 : 4); l++) begin
      li = hf ? {16'd0, s[16*l +: 16]} : s[32*l +: 32];
      rr = tf ? ref_f2i(li, hf, sg, fb) : ref_i2f(li, hf, sg, fb);
      if (hf) nv[16*l +: 16] = rr[15:0];
      else    nv[32*l +: 32] = rr[31:0];
      if (pr[l * (hf ? 2 : 4)]) acc = acc | rr[35:32];
    end
    for (int b = 0; b < 16; b++) ev[8*b +: 8] = pr[b] ? nv[8*b +: 8] : o[8*b +: 8];
    model_flags = model_flags | acc;
    q_d.push_back(ev); q_f.push_back(model_flags); q_r.push_back(req);
    @(negedge clk);
    valid_in = 1'b1; to_fixed = tf; int_signed = sg; half_lanes = hf;
    frac_bits = 6'(fb); lane_pred = pr; src_vec = s; dst_old = o;
  endtask

  task automatic idle(int n);
    @(negedge clk);
    valid_in = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_flags = '0;
    repeat (3) @(negedge clk);
    check("R12", {valid_out, dst_new, flags}, '0);
    rst_n = 1'b1;
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rst_n && valid_out) begin
      if (q_d.size() == 0) check("R10", 128'd1, 128'd0);
      else begin
        string r;
        logic [127:0] d;
        logic [3:0] f;
        d = q_d.pop_front(); f = q_f.pop_front(); r = q_r.pop_front();
        check(r, dst_new, d);
        check("R9", {124'd0, flags}, {124'd0, f});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_run++; n_fail++;
      $display("FAIL R10: watchdog actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    do_reset();
    // fixed to float, back to back
    issue("R2", 0, 1, 1, 1, 16'hFFFF,
          {16'h1234, 16'h0400, 16'h8000, 16'h7FFF, 16'h0000, 16'h0003, 16'hFFFF, 16'h0001},
          {4{32'hDEADBEEF}});
    issue("R6", 0, 0, 1, 16, 16'hFFFF,
          {16'h0002, 16'h0003, 16'h8000, 16'h07FF, 16'h0004, 16'h0001, 16'hFFFF, 16'h0000},
          '0);
    issue("R11", 0, 1, 0, 32, 16'hFFFF,
          {32'h80000000, 32'h7FFFFFFF, 32'h00000001, 32'hFFFFFFFF}, '0);
    issue("R2", 0, 0, 0, 1, 16'hFFFF,
          {32'hFFFFFFFF, 32'h00000003, 32'h80000001, 32'h01000001}, '0);
    idle(4);
    do_reset();
    check("R9", {124'd0, flags}, '0);
    // lane 0 NaN with low bit clear, lane 3 inexact with low bit clear
    issue("R8", 1, 1, 0, 1, 16'b0010_1111_0000_1110,
          {32'h3E800000, 32'h3FC00000, 32'h7F800000, 32'h7FC00000},
          {4{32'hA5A5A5A5}});
    idle(4);
    check("R8", {124'd0, flags}, '0);
    issue("R4", 1, 1, 1, 1, 16'hFFFF,
          {16'hFC00, 16'h7BFF, 16'h3555, 16'h0001, 16'h7E00, 16'h7C00, 16'hBE00, 16'h3E00},
          '0);
    issue("R5", 1, 0, 1, 1, 16'hFFFF,
          {16'h5BFF, 16'h8000, 16'h0000, 16'h8001, 16'h7BFF, 16'h3C00, 16'hB400, 16'hBC00},
          '0);
    issue("R4", 1, 1, 0, 1, 16'hFFFF,
          {32'h3F800001, 32'hCF000000, 32'hCE800000, 32'h4F000000}, '0);
    issue("R11", 1, 0, 0, 32, 16'hFFFF,
          {32'hBF000000, 32'h00400000, 32'h3F7FFFFF, 32'h3F800000}, '0);
    issue("R3", 1, 1, 1, 16, 16'hFFFF,
          {16'h3C00, 16'hB800, 16'h1400, 16'h3555, 16'h0400, 16'h7800, 16'h2E66, 16'hA001},
          '0);
    issue("R7", 0, 1, 1, 3, 16'hA5C3,
          {16'h0011, 16'h2222, 16'h3333, 16'h4444, 16'h5555, 16'h6666, 16'h7777, 16'h8888},
          {8{16'hC0DE}});
    idle(4);
    do_reset();
    for (int i = 0; i < 40; i++) begin
      bit hf;
      hf = 1'($urandom);
      issue("R1", 1'($urandom), 1'($urandom), hf,
            hf ? int'($urandom_range(16, 1)) : int'($urandom_range(32, 1)),
            16'($urandom),
            {$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom});
    end
    idle(6);
    check("R10", 128'(q_d.size()), '0);
    finish_run();
  end
endmodule